// File: doc/BRIEF.md
# Mains-Locked Sixteen-Step Lamp Dimmer

This block sets the brightness of an incandescent lamp in one of sixteen steps. It works in periods that start at each rising edge of a zero-crossing reference taken from the mains, so a load always switches on close to zero volts. Another block supplies a one-cycle step tick fourteen times per mains cycle. That is 840 ticks per second on 60 Hz mains and 700 on 50 Hz mains. The block counts these ticks inside the current period.

The ticks fill a fourteen-bit phase vector as a thermometer. One more output goes high with each tick and stays high until the next period begins. The lamp output is taken from one of those phase bits, chosen by the brightness code that was captured at the start of the period. Code 0 keeps the lamp dark for the whole period. Code 15 keeps it lit for the whole period. A code n from 1 to 14 lights the lamp after 15−n ticks, so a larger code gives a longer on-time.

Top module: `mains_dimmer`

## Requirements
- R1: While `rstN` is low, and at the first sample after reset is released, `phaseOut` is all zeros, `stepCount` is 0 and `lampOut` is 0.
- R2: Each `stepTick` outside a restart cycle adds one to `stepCount`. The count stops at 13 and never wraps back to 0 until the next restart.
- R3: After k ticks in a period, bits 0 to min(k,14)−1 of `phaseOut` are 1 and all higher bits are 0. Bit j therefore rises on the tick that ends step j.
- R4: `zeroCrossIn` passes through two synchronizer flops, and its rising edge is then detected. A 0-to-1 change seen at clock edge e clears `stepCount` and `phaseOut` at edge e+2. This holds even in the middle of a period.
- R5: A falling edge of `zeroCrossIn`, or a steady level on it, clears nothing. Counting continues as before.
- R6: `levelIn` is captured only at the restart edge. Changing it later in the period has no effect on `lampOut`.
- R7: Code 0 holds `lampOut` at 0 for the whole period. Code 15 holds it at 1 for the whole period, from the restart edge on.
- R8: For a code n from 1 to 14, `lampOut` equals `phaseOut` bit 14−n. The lamp is therefore 0 for the first 14−n ticks and 1 from tick 15−n onward.
- R9: A `stepTick` that arrives in the same cycle as the restart is dropped. After that edge the count is 0 and the phases are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| stepTick | input | 1 | One-cycle pulse, 14 per mains cycle |
| zeroCrossIn | input | 1 | Asynchronous zero-crossing reference; its rising edge starts a period |
| levelIn | input | 4 | Brightness code 0..15 |
| phaseOut | output | 14 | Thermometer of elapsed steps in the period |
| stepCount | output | 4 | Saturating step count, 0..13 |
| lampOut | output | 1 | Lamp enable |

## Verification
A tick takes effect on `stepCount`, `phaseOut` and `lampOut` at the first clock edge after it is driven. A zero-crossing rise needs three edges: two synchronizer stages and the edge-detect register. The clear is therefore visible after the third edge that follows the input change. The bench drives one stimulus per cycle at the falling edge. At that same moment it pushes the predicted outputs for the coming rising edge into a queue, using a reference model that copies this latency from the requirements. The monitor pops one entry 2 ns after each rising edge and compares all three outputs, so every check lines up with the edge on which the result is due.

// File: rtl/dimmer_pkg.sv
package dimmer_pkg;
  localparam int PHASES = 14;
  localparam int CNT_W  = $clog2(PHASES);
  localparam int LVL_W  = $clog2(PHASES + 2);

  typedef struct packed {
    logic restart;
    logic advance;
  } dimStrobe_t;
endpackage

// File: rtl/dimmer_ctrl.sv
module dimmer_ctrl
  import dimmer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepTick,
  input  logic       zeroCrossIn,
  output dimStrobe_t strobe
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   edgePrevQ;
  logic                   zcSynced;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ     <= '0;
      edgePrevQ <= 1'b0;
    end else begin
      syncQ     <= {syncQ[SYNC_STAGES-2:0], zeroCrossIn};
      edgePrevQ <= zcSynced;
    end
  end

  assign zcSynced = syncQ[SYNC_STAGES-1];

  always_comb begin
    strobe.restart = zcSynced & ~edgePrevQ;
    strobe.advance = stepTick & ~strobe.restart;
  end

  // R4: a detected rise lasts exactly one cycle
  assert_restart_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> !strobe.restart);

  // R5: no restart while the synchronized level is falling or steady low
  assert_no_restart_on_fall_R5: assert property (@(posedge clk) disable iff (!rstN)
    !zcSynced |-> !strobe.restart);
endmodule

// File: rtl/dimmer_datapath.sv
module dimmer_datapath
  import dimmer_pkg::*;
#(
  parameter int NPH  = PHASES,
  parameter int CW   = CNT_W,
  parameter int LW   = LVL_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dimStrobe_t    strobe,
  input  logic [LW-1:0] levelIn,
  output logic [NPH-1:0] phaseOut,
  output logic [CW-1:0] stepCount,
  output logic          lampOut
);
  localparam logic [CW-1:0] LAST_STEP = CW'(NPH - 1);
  localparam logic [LW-1:0] FULL_ON   = LW'(NPH + 1);

  logic [NPH-1:0] phaseQ;
  logic [CW-1:0]  countQ;
  logic [LW-1:0]  levelQ;
  logic [NPH:0]   pickVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
      countQ <= '0;
      levelQ <= '0;
    end else if (strobe.restart) begin
      phaseQ <= '0;
      countQ <= '0;
      levelQ <= levelIn;
    end else if (strobe.advance) begin
      phaseQ <= {phaseQ[NPH-2:0], 1'b1};
      if (countQ != LAST_STEP) countQ <= countQ + 1'b1;
    end
  end

  // one candidate per code: slot 0 is dark, slot n takes phase bit NPH-n
  assign pickVec[0] = 1'b0;
  for (genvar n = 1; n <= NPH; n++) begin : g_pick
    assign pickVec[n] = phaseQ[NPH-n];
  end

  always_comb begin
    lampOut = 1'b0;
    if (levelQ >= FULL_ON) lampOut = 1'b1;
    else begin
      for (int n = 0; n <= NPH; n++) begin
        if (levelQ == LW'(n)) lampOut = pickVec[n];
      end
    end
  end

  assign phaseOut  = phaseQ;
  assign stepCount = countQ;

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= LAST_STEP);

  assert_count_saturate_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && countQ == LAST_STEP) |=> countQ == LAST_STEP);

  assert_phase_thermo_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ & (phaseQ + 1'b1)) == '0);

  assert_restart_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (countQ == '0 && phaseQ == '0));

  assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.restart |=> $stable(levelQ));

  assert_full_on_R7: assert property (@(posedge clk) disable iff (!rstN)
    levelQ == FULL_ON |-> lampOut);
endmodule

// File: rtl/mains_dimmer.sv
module mains_dimmer
  import dimmer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              stepTick,
  input  logic              zeroCrossIn,
  input  logic [LVL_W-1:0]  levelIn,
  output logic [PHASES-1:0] phaseOut,
  output logic [CNT_W-1:0]  stepCount,
  output logic              lampOut
);
  dimStrobe_t strobe;

  dimmer_ctrl #(.SYNC_STAGES(2)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .stepTick   (stepTick),
    .zeroCrossIn(zeroCrossIn),
    .strobe     (strobe)
  );

  dimmer_datapath #(.NPH(PHASES), .CW(CNT_W), .LW(LVL_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .levelIn  (levelIn),
    .phaseOut (phaseOut),
    .stepCount(stepCount),
    .lampOut  (lampOut)
  );
endmodule

// File: tb/test_mains_dimmer.sv
module test_mains_dimmer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepTick = 1'b0;
  logic        zeroCrossIn = 1'b0;
  logic [3:0]  levelIn = 4'd0;
  logic [13:0] phaseOut;
  logic [3:0]  stepCount;
  logic        lampOut;

  mains_dimmer i_mains_dimmer (
    .clk(clk), .rstN(rstN), .stepTick(stepTick), .zeroCrossIn(zeroCrossIn),
    .levelIn(levelIn), .phaseOut(phaseOut), .stepCount(stepCount), .lampOut(lampOut)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [13:0] ph;
    logic [3:0]  cnt;
    logic        lamp;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t popped;
  int checks = 0;
  int errors = 0;

  // reference model state
  logic [13:0] mPh = '0;
  logic [3:0]  mCnt = '0;
  logic [3:0]  mLvl = '0;
  logic        mS1 = 0, mS2 = 0, mPrev = 0;

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  // monitor: compare one item per rising edge, 2 ns after it
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      popped = expQ.pop_front();
      checks++;
      if (phaseOut !== popped.ph || stepCount !== popped.cnt || lampOut !== popped.lamp) begin
        errors++;
        $display("FAIL %s phase=%h/%h count=%0d/%0d lamp=%b/%b (actual/expected)",
                 popped.tag, phaseOut, popped.ph, stepCount, popped.cnt, lampOut, popped.lamp);
      end
    end
  end

  // driver: one cycle, called at a falling edge
  task automatic cycle(input logic t, input string tag);
    logic restart;
    expItem_t it;
    stepTick = t;
    restart = mS2 & ~mPrev;
    if (restart) begin
      mPh = '0; mCnt = '0; mLvl = levelIn;
    end else if (t) begin
      mPh = {mPh[12:0], 1'b1};
      if (mCnt < 4'd13) mCnt = mCnt + 1'b1;
    end
    mPrev = mS2; mS2 = mS1; mS1 = zeroCrossIn;
    it.ph = mPh; it.cnt = mCnt; it.tag = tag;
    if (mLvl == 0) it.lamp = 1'b0;
    else if (mLvl == 15) it.lamp = 1'b1;
    else it.lamp = mPh[14 - mLvl];
    expQ.push_back(it);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(1'b1, tag);
  endtask

  // new period: rise on zeroCrossIn, then idle until the clear has landed
  task automatic startPeriod(input logic [3:0] lvl, input string tag);
    zeroCrossIn = 1'b0;
    cycle(1'b0, tag);
    levelIn = lvl;
    zeroCrossIn = 1'b1;
    for (int i = 0; i < 4; i++) cycle(1'b0, tag);
  endtask

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    checks++;
    if (phaseOut !== '0 || stepCount !== '0 || lampOut !== 1'b0) begin
      errors++;
      $display("FAIL R1 phase=%h/0 count=%0d/0 lamp=%b/0", phaseOut, stepCount, lampOut);
    end
    rstN = 1'b1;
    cycle(1'b0, "R1");

    // code 14: lamp from first tick; count saturates, thermometer fills
    startPeriod(4'd14, "R4");
    ticks(3, "R8");
    ticks(17, "R2");
    // falling edge and steady low do not clear
    zeroCrossIn = 1'b0;
    for (int i = 0; i < 5; i++) cycle(1'b0, "R5");
    ticks(2, "R5");

    // code 1: lamp only after the 14th tick
    startPeriod(4'd1, "R4");
    for (int i = 0; i < 16; i++) cycle(i % 2 == 0, "R8");

    // mid-period restart with partial fill, code 9
    startPeriod(4'd9, "R4");
    ticks(5, "R3");
    startPeriod(4'd9, "R4");
    ticks(7, "R8");

    // code 15 with a tick on every cycle, including the restart cycle
    zeroCrossIn = 1'b0;
    cycle(1'b1, "R9");
    levelIn = 4'd15;
    zeroCrossIn = 1'b1;
    for (int i = 0; i < 4; i++) cycle(1'b1, "R9");
    ticks(3, "R7");
    // change code mid-period: lamp stays lit
    levelIn = 4'd0;
    ticks(12, "R6");

    // code 0: dark through a full period, even after a later code change
    startPeriod(4'd0, "R7");
    ticks(8, "R7");
    levelIn = 4'd14;
    ticks(8, "R6");

    // code 7, interleaved ticks
    startPeriod(4'd7, "R4");
    for (int i = 0; i < 24; i++) cycle(i % 3 != 1, "R3");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule